// File: doc/BRIEF.md
# Rotating Priority Bus Arbiter

This block decides which of up to sixteen agents may use a shared interrupt-message bus next. Each agent has a static identity number and a hidden arbitration level of the same width. When a round is started, the requesting agent with the largest level wins. The block then rewrites the levels so that access rotates: the winner falls to the bottom, and every requester that lost moves one step up. Agents that did not request keep their level.

The levels are loaded from the identity numbers at reset. A resynchronize strobe reloads them the same way, which puts every agent back into a known order after the agents have drifted apart. The grant appears as a one-cycle one-hot pulse together with the winner's index. The current levels are brought out so that the surrounding logic can observe them.

Top module: `rot_prio_arbiter`

## Requirements
- R1: While `rstN` is low at a clock edge, every level is loaded from its identity field and `grant` is all zero after that edge. Field i of `agentIds` and of `prioOut` occupies bits [4i+3:4i].
- R2: A clock edge with `roundStart` high, `resync` low and a nonzero `reqVec` produces, after that edge, a `grant` whose only set bit (bit i for agent i) belongs to the requester with the largest level, and `winnerIdx` equal to that agent's index.
- R3: When several requesters share the largest level, the one with the highest index wins.
- R4: After a round, the winner's level is 0.
- R5: After a round, each losing requester's level is one higher, except that a level of 15 stays at 15.
- R6: Agents whose `reqVec` bit is low keep their level through a round.
- R7: A `roundStart` edge with `reqVec` all zero issues no grant and changes no level.
- R8: `grant` is high for exactly the one cycle after a qualifying round edge and zero in every other cycle.
- R9: A clock edge with `resync` high reloads every level from the current `agentIds`.
- R10: When `resync` and `roundStart` are high at the same edge, the reload happens and no grant is issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| agentIds | input | 64 | Static identity number of each agent, 4 bits per agent |
| reqVec | input | 16 | Request bit per agent for the round |
| roundStart | input | 1 | Starts an arbitration round at this edge |
| resync | input | 1 | Reloads all levels from `agentIds` |
| grant | output | 16 | One-hot grant, valid for one cycle |
| winnerIdx | output | 4 | Index of the last winner; meaningful while `grant` is nonzero |
| prioOut | output | 64 | Current arbitration level of each agent, 4 bits per agent |

## Verification
The hardest state to reach is a loser that already sits at level 15, since with distinct identity numbers the top level is held by one agent at a time and losing to it is impossible. The stimulus loads duplicate identity numbers so that two agents start level at 15, then runs a round between them: the higher index wins and the lower one must stay at 15. A second identity set is then loaded through `resync`, and a long stretch of random requests, strobes and occasional resynchronizations is compared cycle by cycle with a behavioural model.

// File: rtl/arb_pkg.sv
package arb_pkg;

  // Strobes the control stage hands to the datapath each cycle.
  typedef struct packed {
    logic loadIds;   // copy identity numbers into the level registers
    logic commit;    // perform an arbitration round at this edge
    logic clearIdx;  // clear the winner index register
  } arbStrobes_t;

endpackage

// File: rtl/arb_ctrl.sv
module arb_ctrl
  import arb_pkg::*;
(
  input  logic        rstN,
  input  logic        roundStart,
  input  logic        resync,
  input  logic        anyReq,
  output arbStrobes_t strb
);

  logic inReset;
  logic reloadReq;
  logic roundReq;

  always_comb begin
    inReset   = !rstN;
    // Reload wins over a round in the same cycle.
    reloadReq = inReset || resync;
    roundReq  = roundStart && anyReq && !reloadReq;

    strb          = '0;
    strb.loadIds  = reloadReq;
    strb.commit   = roundReq;
    strb.clearIdx = inReset;
  end

endmodule

// File: rtl/arb_pick.sv
module arb_pick #(
  parameter int NUM_AGENTS = 16,
  parameter int PRIO_W     = 4,
  localparam int IDX_W     = $clog2(NUM_AGENTS)
) (
  input  logic [NUM_AGENTS*PRIO_W-1:0] prioFlat,
  input  logic [NUM_AGENTS-1:0]        reqVec,
  output logic [IDX_W-1:0]             winIdx,
  output logic                         anyReq
);

  logic [PRIO_W-1:0] prioArr [NUM_AGENTS];

  for (genvar g = 0; g < NUM_AGENTS; g++) begin : g_unpack
    assign prioArr[g] = prioFlat[g*PRIO_W +: PRIO_W];
  end

  logic [PRIO_W-1:0] bestPrio;
  logic [IDX_W-1:0]  bestIdx;
  logic              found;

  // Linear scan from low to high index; ">=" lets a later (higher index)
  // requester take over on equal level.
  always_comb begin
    bestPrio = '0;
    bestIdx  = '0;
    found    = 1'b0;
    for (int i = 0; i < NUM_AGENTS; i++) begin
      if (reqVec[i] && (!found || prioArr[i] >= bestPrio)) begin
        found    = 1'b1;
        bestPrio = prioArr[i];
        bestIdx  = IDX_W'(i);
      end
    end
  end

  assign winIdx = bestIdx;
  assign anyReq = found;

endmodule

// File: rtl/arb_datapath.sv
module arb_datapath
  import arb_pkg::*;
#(
  parameter int NUM_AGENTS = 16,
  parameter int PRIO_W     = 4,
  localparam int IDX_W     = $clog2(NUM_AGENTS)
) (
  input  logic                         clk,
  input  arbStrobes_t                  strb,
  input  logic [NUM_AGENTS*PRIO_W-1:0] agentIds,
  input  logic [NUM_AGENTS-1:0]        reqVec,
  output logic                         anyReq,
  output logic [NUM_AGENTS-1:0]        grant,
  output logic [IDX_W-1:0]             winnerIdx,
  output logic [NUM_AGENTS*PRIO_W-1:0] prioFlat
);

  localparam logic [PRIO_W-1:0] PRIO_TOP = '1;

  logic [PRIO_W-1:0]     prioReg [NUM_AGENTS];
  logic [IDX_W-1:0]      winIdx;
  logic [NUM_AGENTS-1:0] grantNext;

  for (genvar g = 0; g < NUM_AGENTS; g++) begin : g_pack
    assign prioFlat[g*PRIO_W +: PRIO_W] = prioReg[g];
  end

  arb_pick #(
    .NUM_AGENTS (NUM_AGENTS),
    .PRIO_W     (PRIO_W)
  ) i_pick (
    .prioFlat (prioFlat),
    .reqVec   (reqVec),
    .winIdx   (winIdx),
    .anyReq   (anyReq)
  );

  // One level register per agent.
  for (genvar g = 0; g < NUM_AGENTS; g++) begin : g_level
    logic isWinner;
    assign isWinner = (winIdx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (strb.loadIds) begin
        prioReg[g] <= agentIds[g*PRIO_W +: PRIO_W];
      end else if (strb.commit && reqVec[g]) begin
        if (isWinner) begin
          prioReg[g] <= '0;
        end else if (prioReg[g] != PRIO_TOP) begin
          prioReg[g] <= prioReg[g] + 1'b1;
        end
      end
    end
  end

  always_comb begin
    grantNext         = '0;
    grantNext[winIdx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (strb.commit) begin
      grant <= grantNext;
    end else begin
      grant <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (strb.clearIdx) begin
      winnerIdx <= '0;
    end else if (strb.commit) begin
      winnerIdx <= winIdx;
    end
  end

endmodule

// File: rtl/rot_prio_arbiter.sv
module rot_prio_arbiter
  import arb_pkg::*;
#(
  parameter int NUM_AGENTS = 16,
  parameter int PRIO_W     = 4,
  localparam int IDX_W     = $clog2(NUM_AGENTS)
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [NUM_AGENTS*PRIO_W-1:0] agentIds,
  input  logic [NUM_AGENTS-1:0]        reqVec,
  input  logic                         roundStart,
  input  logic                         resync,
  output logic [NUM_AGENTS-1:0]        grant,
  output logic [IDX_W-1:0]             winnerIdx,
  output logic [NUM_AGENTS*PRIO_W-1:0] prioOut
);

  arbStrobes_t strb;
  logic        anyReq;

  arb_ctrl i_ctrl (
    .rstN       (rstN),
    .roundStart (roundStart),
    .resync     (resync),
    .anyReq     (anyReq),
    .strb       (strb)
  );

  arb_datapath #(
    .NUM_AGENTS (NUM_AGENTS),
    .PRIO_W     (PRIO_W)
  ) i_dp (
    .clk       (clk),
    .strb      (strb),
    .agentIds  (agentIds),
    .reqVec    (reqVec),
    .anyReq    (anyReq),
    .grant     (grant),
    .winnerIdx (winnerIdx),
    .prioFlat  (prioOut)
  );

endmodule

// File: rtl/arb_checker.sv
module arb_checker #(
  parameter int NUM_AGENTS = 16,
  parameter int PRIO_W     = 4,
  localparam int IDX_W     = $clog2(NUM_AGENTS)
) (
  input logic                         clk,
  input logic                         rstN,
  input logic [NUM_AGENTS*PRIO_W-1:0] agentIds,
  input logic [NUM_AGENTS-1:0]        reqVec,
  input logic                         roundStart,
  input logic                         resync,
  input logic [NUM_AGENTS-1:0]        grant,
  input logic [IDX_W-1:0]             winnerIdx,
  input logic [NUM_AGENTS*PRIO_W-1:0] prioOut
);

  logic [PRIO_W-1:0] winnerLevel;
  assign winnerLevel = prioOut[winnerIdx*PRIO_W +: PRIO_W];

  // R8
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grant));

  // R8
  grant_after_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|grant) |-> $past(roundStart && !resync && rstN));

  // R7
  grant_to_requester_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|grant) |-> (($past(reqVec) & grant) != '0));

  // R2
  index_matches_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|grant) |-> grant[winnerIdx]);

  // R4
  winner_at_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|grant) |-> (winnerLevel == '0));

  // R10
  resync_blocks_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(resync) |-> (grant == '0));

  // R9
  resync_reload_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(resync) && $past(rstN)) |-> (prioOut == $past(agentIds)));

  // R6
  idle_levels_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(!roundStart && !resync)) |-> $stable(prioOut));

endmodule

bind rot_prio_arbiter arb_checker #(
  .NUM_AGENTS (NUM_AGENTS),
  .PRIO_W     (PRIO_W)
) i_arb_checker (
  .clk        (clk),
  .rstN       (rstN),
  .agentIds   (agentIds),
  .reqVec     (reqVec),
  .roundStart (roundStart),
  .resync     (resync),
  .grant      (grant),
  .winnerIdx  (winnerIdx),
  .prioOut    (prioOut)
);

// File: tb/test_rot_prio_arbiter.sv
module test_rot_prio_arbiter;

  localparam int CLK_PERIOD = 10;
  localparam int N  = 16;
  localparam int PW = 4;

  logic          clk = 1'b0;
  logic          rstN;
  logic [N*PW-1:0] agentIds;
  logic [N-1:0]  reqVec;
  logic          roundStart;
  logic          resync;
  logic [N-1:0]  grant;
  logic [3:0]    winnerIdx;
  logic [N*PW-1:0] prioOut;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // Behavioural reference state.
  int mLevel[N];
  int mGrantIdx;     // -1 when no grant expected
  string mTag;

  always #(CLK_PERIOD/2) clk = ~clk;

  rot_prio_arbiter i_rot_prio_arbiter (
    .clk        (clk),
    .rstN       (rstN),
    .agentIds   (agentIds),
    .reqVec     (reqVec),
    .roundStart (roundStart),
    .resync     (resync),
    .grant      (grant),
    .winnerIdx  (winnerIdx),
    .prioOut    (prioOut)
  );

  function automatic int levelOf(int i);
    return int'(prioOut[i*PW +: PW]);
  endfunction

  task automatic check(bit ok, string tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Model update for one clock edge, using the inputs the bench drove.
  task automatic modelEdge();
    int best;
    int win;
    mGrantIdx = -1;
    if (!rstN || resync) begin
      for (int i = 0; i < N; i++) mLevel[i] = int'(agentIds[i*PW +: PW]);
      mTag = !rstN ? "R1" : (roundStart ? "R10" : "R9");
    end else if (roundStart && reqVec != '0) begin
      best = -1;
      win  = 0;
      for (int i = 0; i < N; i++) begin
        if (reqVec[i] && mLevel[i] >= best) begin
          best = mLevel[i];
          win  = i;
        end
      end
      for (int i = 0; i < N; i++) begin
        if (i == win) mLevel[i] = 0;
        else if (reqVec[i] && mLevel[i] < 15) mLevel[i] = mLevel[i] + 1;
      end
      mGrantIdx = win;
      mTag = "R2/R4/R5/R6";
    end else begin
      mTag = roundStart ? "R7" : "R8";
    end
  endtask

  task automatic compareAll();
    logic [N-1:0]    expGrant;
    logic [N*PW-1:0] expLevels;
    expGrant = '0;
    if (mGrantIdx >= 0) expGrant[mGrantIdx] = 1'b1;
    for (int i = 0; i < N; i++) expLevels[i*PW +: PW] = PW'(mLevel[i]);
    check(grant === expGrant, mTag, "grant", longint'(grant), longint'(expGrant));
    if (mGrantIdx >= 0)
      check(int'(winnerIdx) == mGrantIdx, "R2", "winnerIdx", longint'(winnerIdx), longint'(mGrantIdx));
    check(prioOut === expLevels, mTag, "levels", longint'(prioOut), longint'(expLevels));
  endtask

  // Drive after a falling edge, step one rising edge, compare at the next falling edge.
  task automatic doCycle(bit r, logic [N-1:0] rq, bit rs, bit sy);
    rstN       = r;
    reqVec     = rq;
    roundStart = rs;
    resync     = sy;
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    compareAll();
  endtask

  initial begin
    #(CLK_PERIOD*150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired at %0t", $time);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // Identity set A: agent i holds i, except agents 14 and 15 both hold 15.
    for (int i = 0; i < N; i++) agentIds[i*PW +: PW] = (i >= 14) ? 4'hF : PW'(i);
    rstN = 1'b0; reqVec = '0; roundStart = 1'b0; resync = 1'b0;
    for (int i = 0; i < N; i++) mLevel[i] = 0;
    mGrantIdx = -1;

    doCycle(0, '0, 0, 0);
    doCycle(0, 16'hFFFF, 1, 0);
    doCycle(0, '0, 0, 0);
    // R1: levels equal identity numbers, no grant
    check(levelOf(7) == 7 && levelOf(15) == 15, "R1", "reset level", longint'(prioOut), 0);
    check(grant == '0, "R1", "reset grant", longint'(grant), 0);

    // R8: requests without a round strobe give nothing
    doCycle(1, 16'h00F0, 0, 0);
    check(grant == '0, "R8", "no strobe grant", longint'(grant), 0);

    // R7: strobe with no request
    doCycle(1, '0, 1, 0);
    check(grant == '0, "R7", "empty round grant", longint'(grant), 0);
    check(levelOf(3) == 3, "R7", "empty round level", levelOf(3), 3);

    // R3, R5: tie at 15 between agents 14 and 15; higher index wins, loser saturates
    doCycle(1, 16'hC000, 1, 0);
    check(grant == 16'h8000, "R3", "tie grant", longint'(grant), 64'h8000);
    check(winnerIdx == 4'd15, "R3", "tie index", longint'(winnerIdx), 15);
    check(levelOf(14) == 15, "R5", "saturated loser", levelOf(14), 15);
    check(levelOf(15) == 0, "R4", "winner level", levelOf(15), 0);

    // R8: grant gone the next cycle
    doCycle(1, 16'hC000, 0, 0);
    check(grant == '0, "R8", "grant one cycle", longint'(grant), 0);

    // R2, R5, R6: agents 3 and 9 compete
    doCycle(1, 16'h0208, 1, 0);
    check(grant == 16'h0200, "R2", "grant 9", longint'(grant), 64'h0200);
    check(levelOf(3) == 4, "R5", "loser up", levelOf(3), 4);
    check(levelOf(5) == 5, "R6", "bystander", levelOf(5), 5);

    // R10: resync and round together
    doCycle(1, 16'h0208, 1, 1);
    check(grant == '0, "R10", "collision grant", longint'(grant), 0);
    check(levelOf(9) == 9 && levelOf(15) == 15, "R10", "collision reload", longint'(prioOut), 0);

    // R9: new identity set B (agent i holds 15-i), then resync
    for (int i = 0; i < N; i++) agentIds[i*PW +: PW] = PW'(15 - i);
    doCycle(1, '0, 0, 1);
    check(levelOf(0) == 15 && levelOf(15) == 0, "R9", "reload set B", longint'(prioOut), 0);

    // Random phase, compared with the model every cycle.
    for (int k = 0; k < 4000; k++) begin
      logic [N-1:0] rq;
      bit rs;
      bit sy;
      bit rr;
      rq = N'($urandom);
      if ($urandom_range(0, 3) == 0) rq = rq & N'($urandom);
      if ($urandom_range(0, 9) == 0) rq = '0;
      rs = ($urandom_range(0, 2) != 0);
      sy = ($urandom_range(0, 39) == 0);
      rr = ($urandom_range(0, 499) != 0);
      doCycle(rr, rq, rs, sy);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule